// File: doc/BRIEF.md
# Keyed Write Guard for a Critical Control Register

This block holds one control register whose accidental modification could stop the chip, for example the selector of a clock source. It sits on a plain single-cycle register bus with an address, a write strobe, write data and combinational read data. A write to the protected address changes nothing unless two key values have first been written to that same address, in a fixed order. The write that follows a valid key is the only one accepted. It loads the register and the guard locks itself again.

The key writes must arrive in order, but they need not be adjacent. Writes to any other address, before, between or after the keys, are seen by the block and ignored. A wrong value at either key step either leaves the guard idle or drops it back to idle. The register contents drive a dedicated output. The armed state is shown on an output pin and in a read-only status word.

Top module: `ulk_reg_guard`

## Requirements
- R1: After reset the protected register holds RESET_VAL (default 0xA0), the guard is locked, and write_armed is 0.
- R2: A write to the protected address (PROT_ADDR, default 0x10) while the guard is not armed leaves the register value unchanged.
- R3: A write of KEY_FIRST (0xE7) to the protected address, followed by a later write of KEY_SECOND (0x18) to that address, arms the guard: write_armed becomes 1 in the cycle after the second key write.
- R4: The keys in reverse order (0x18, then 0xE7) do not arm the guard.
- R5: Writes to any address other than PROT_ADDR do not change the guard state, whether they come between the two keys or between the second key and the data write.
- R6: While armed, the next write to the protected address loads its data into the register and returns the guard to locked, both visible one cycle after the write.
- R7: While idle, a write of any value other than 0xE7 to the protected address keeps the guard idle, so a correct key that follows still arms it.
- R8: After the first key, any value other than 0x18 written to the protected address returns the guard to idle. This includes a repeated 0xE7, so E7, E7, 18 does not arm.
- R9: Reading PROT_ADDR returns the register value. Reading STAT_ADDR (default 0x11) returns bit 0 = armed and bit 1 = first key seen, with all other bits 0. Reading any other address returns 0.
- R10: Only one data write is accepted per key: a second write after the loading write does not change the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address for write and read |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for bus_addr |
| ctrl_value | output | DATA_W | Contents of the protected register |
| write_armed | output | 1 | 1 when the next protected write will be accepted |

## Verification
The hardest state to reach from the ports is the armed state after foreign-address traffic has been interleaved at both gaps. The bench gets there by placing writes to unrelated and status addresses between the two keys and again before the data write. It then checks that exactly one data write takes effect. The second hard case is a partial key that is broken by a repeated first key. The stimulus writes E7, E7 and then 18, and checks that the guard stays locked. It then confirms that a clean key sequence still works afterwards.

// File: rtl/ulk_guard_pkg.sv
package ulk_guard_pkg;

  typedef enum logic [1:0] {
    GS_IDLE  = 2'd0,
    GS_HALF  = 2'd1,
    GS_ARMED = 2'd2
  } guard_st_e;

  // Next guard state for one bus cycle.
  // hit: write strobe to the protected address in this cycle.
  function automatic guard_st_e guard_next(guard_st_e cur, logic hit,
                                           logic is_first, logic is_second);
    guard_st_e nxt;
    nxt = cur;
    if (hit) begin
      unique case (cur)
        GS_IDLE:  nxt = is_first  ? GS_HALF  : GS_IDLE;
        GS_HALF:  nxt = is_second ? GS_ARMED : GS_IDLE;
        GS_ARMED: nxt = GS_IDLE;
        default:  nxt = GS_IDLE;
      endcase
    end
    return nxt;
  endfunction

endpackage

// File: rtl/ulk_key_fsm.sv
module ulk_key_fsm
  import ulk_guard_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hE7,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic              armed,
  output logic              first_seen,
  output logic              load_en
);

  guard_st_e st_q, st_d;
  logic      match_first, match_second;

  assign match_first  = (wdata == KEY_FIRST);
  assign match_second = (wdata == KEY_SECOND);
  assign st_d         = guard_next(st_q, prot_hit, match_first, match_second);

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= GS_IDLE;
    else        st_q <= st_d;
  end

  assign armed      = (st_q == GS_ARMED);
  assign first_seen = (st_q == GS_HALF);
  assign load_en    = armed && prot_hit;

  // R3: a second key after the first arms the guard
  p_arm_on_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_hit && first_seen && match_second) |=> armed);

  // R5: cycles without a protected write keep the state
  p_foreign_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_hit) |=> (st_q == $past(st_q)));

  // R8: a wrong second key drops back to idle
  p_bad_second_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_hit && first_seen && !match_second) |=> (!armed && !first_seen));

  // R7: a non-key write in idle stays idle
  p_idle_stay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_hit && !armed && !first_seen && !match_first) |=> (!armed && !first_seen));

endmodule

// File: rtl/ulk_guard_reg.sv
module ulk_guard_reg #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RESET_VAL = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              prot_hit,
  input  logic              armed,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value
);

  always_ff @(posedge clk) begin
    if (!rst_n)       value <= RESET_VAL;
    else if (load_en) value <= wdata;
  end

  // R2: a protected write while not armed does not change the value
  p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_hit && !armed) |=> $stable(value));

  // R6: an armed protected write loads data and relocks
  p_load_relock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_hit && armed) |=> (value == $past(wdata) && !armed));

endmodule

// File: rtl/ulk_readback.sv
module ulk_readback #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PROT_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] value,
  input  logic              armed,
  input  logic              first_seen,
  output logic [DATA_W-1:0] rdata
);

  localparam int PAD_W = DATA_W - 2;

  always_comb begin
    if (addr == PROT_ADDR)      rdata = value;
    else if (addr == STAT_ADDR) rdata = {{PAD_W{1'b0}}, first_seen, armed};
    else                        rdata = '0;
  end

  // R9: status bits never show both key stages at once
  always_comb begin
    p_status_onehot_r9: assert ($onehot0({armed, first_seen}));
  end

endmodule

// File: rtl/ulk_reg_guard.sv
module ulk_reg_guard #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PROT_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] STAT_ADDR  = 8'h11,
  parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hE7,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h18,
  parameter logic [DATA_W-1:0] RESET_VAL  = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] ctrl_value,
  output logic              write_armed
);

  logic prot_hit, armed, first_seen, load_en;

  assign prot_hit = bus_we && (bus_addr == PROT_ADDR);

  ulk_key_fsm #(
    .DATA_W(DATA_W), .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .prot_hit(prot_hit), .wdata(bus_wdata),
    .armed(armed), .first_seen(first_seen), .load_en(load_en)
  );

  ulk_guard_reg #(
    .DATA_W(DATA_W), .RESET_VAL(RESET_VAL)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .prot_hit(prot_hit),
    .armed(armed), .wdata(bus_wdata), .value(ctrl_value)
  );

  ulk_readback #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROT_ADDR(PROT_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_rd (
    .addr(bus_addr), .value(ctrl_value), .armed(armed),
    .first_seen(first_seen), .rdata(bus_rdata)
  );

  assign write_armed = armed;

  // R1: right after reset the guard is not armed
  p_reset_locked_r1: assert property (@(posedge clk)
    (!rst_n) |=> !write_armed);

endmodule

// File: tb/sim_ulk_reg_guard.sv
module sim_ulk_reg_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] PA = 8'h10, SA = 8'h11, K1 = 8'hE7, K2 = 8'h18;

  logic       clk = 0, rst_n = 0, bus_we = 0;
  logic [7:0] bus_addr = 0, bus_wdata = 0;
  logic [7:0] bus_rdata, ctrl_value;
  logic       write_armed;
  int n_chk = 0, n_fail = 0;

  ulk_reg_guard u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_value(ctrl_value),
    .write_armed(write_armed));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // one write cycle; outputs are sampled on the following falling edge
  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    bus_addr = a; bus_we = 0; #1; d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1; @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    chk("R1 value", ctrl_value, 8'hA0);
    chk("R1 armed", {7'b0, write_armed}, 8'h00);
  endtask

  task automatic t_locked_write();
    wr(PA, 8'h55);
    chk("R2 locked write", ctrl_value, 8'hA0);
    chk("R2 still locked", {7'b0, write_armed}, 8'h00);
  endtask

  task automatic t_reverse();
    wr(PA, K2); wr(PA, K1);
    chk("R4 reverse not armed", {7'b0, write_armed}, 8'h00);
    wr(PA, 8'h33);
    chk("R4 reverse no load", ctrl_value, 8'hA0);
  endtask

  task automatic t_normal();
    logic [7:0] d;
    do_reset();
    wr(PA, K1);
    rd(SA, d); chk("R9 status half", d, 8'h02);
    wr(PA, K2);
    chk("R3 armed", {7'b0, write_armed}, 8'h01);
    rd(SA, d); chk("R9 status armed", d, 8'h01);
    wr(PA, 8'h3C);
    chk("R6 loaded", ctrl_value, 8'h3C);
    chk("R6 relocked", {7'b0, write_armed}, 8'h00);
    rd(PA, d); chk("R9 read value", d, 8'h3C);
    rd(8'h42, d); chk("R9 other addr", d, 8'h00);
    wr(PA, 8'h77);
    chk("R10 second write ignored", ctrl_value, 8'h3C);
  endtask

  task automatic t_interleave();
    do_reset();
    wr(PA, K1); wr(8'h20, K2); wr(SA, 8'hFF);
    wr(PA, K2);
    chk("R5 arms across foreign writes", {7'b0, write_armed}, 8'h01);
    wr(8'h30, 8'h99); wr(8'h00, K1);
    chk("R5 stays armed", {7'b0, write_armed}, 8'h01);
    wr(PA, 8'hC3);
    chk("R5 load after gap", ctrl_value, 8'hC3);
  endtask

  task automatic t_idle_noise();
    do_reset();
    wr(PA, 8'h00); wr(PA, K2); wr(PA, K1); wr(PA, K2);
    chk("R7 key after noise arms", {7'b0, write_armed}, 8'h01);
    wr(PA, 8'h5A);
    chk("R7 load", ctrl_value, 8'h5A);
  endtask

  task automatic t_bad_second();
    logic [7:0] d;
    do_reset();
    wr(PA, K1); wr(PA, K1); wr(PA, K2);
    chk("R8 E7 E7 18 not armed", {7'b0, write_armed}, 8'h00);
    rd(SA, d); chk("R8 status idle", d, 8'h00);
    wr(PA, K1); wr(PA, 8'h19);
    rd(SA, d); chk("R8 wrong second idle", d, 8'h00);
    wr(PA, 8'h66);
    chk("R8 no load", ctrl_value, 8'hA0);
    wr(PA, K1); wr(PA, K2); wr(PA, 8'h81);
    chk("R8 recovery load", ctrl_value, 8'h81);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_locked_write();
        t_reverse();
        t_normal();
        t_interleave();
        t_idle_noise();
        t_bad_second();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule